// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a register-mapped countdown watchdog clocked by the system clock and advanced by a slow tick strobe. Software programs a 10-bit initial value, clears the halt bit, and then services the watchdog by writing to the reload register. If a full period passes without service, the first expiry raises a timeout flag, drives an interrupt when the interrupt enable input is high, and the counter reloads and keeps running.

If a second full period passes with no service, the second expiry sets a second-timeout flag and, unless the no-reboot input is high, emits a one-cycle system reset request. A reload write at any time returns the watchdog to its first stage. Register access uses a small synchronous write port with byte enables and a combinational read port addressed by byte offset.

Top module: `dual_stage_wdt`

## Requirements
- R1: After reset the halt bit (bit 11 at offset 0x08) is 1, the initial value (bits [9:0] at offset 0x12) is 0x004, the count read at offset 0x00 is 0x004, the boot flag (bit 2 at offset 0x06) is 1, all other flags are 0, and irq and rst_req are low.
- R2: A write to offset 0x12 stores bits [15:10] of the merged word unconditionally and stores bits [9:0] only when that field is 4 or larger; a field of 0 to 3 leaves the previous value, and reads return both parts as stored.
- R3: Any write to offset 0x00 loads the counter from the initial value and returns the watchdog to its first stage; reading offset 0x00 returns the current count in bits [9:0].
- R4: While bit 11 at offset 0x08 is 1 the count does not change on ticks; clearing it lets counting start, and the bit reads back as written.
- R5: Each cycle with tick_en high and halt clear decrements a nonzero count; a tick at count 0 is an expiry and reloads the counter from the initial value, so one period lasts initial value plus one ticks.
- R6: The first expiry sets the first-timeout flag (bit 3 at offset 0x04); irq is high exactly while that flag and irq_enable are both high.
- R7: An expiry with no reload write since the previous expiry is the second expiry: it sets the second-timeout flag (bit 1 at offset 0x06), pulses rst_req for one cycle starting at the same clock edge, and the next expiry counts as a first expiry again.
- R8: With no_reboot high at the second expiry, the second-timeout flag is still set but rst_req stays low.
- R9: Status flags clear when 1 is written to their bit with the low byte enabled; writing 0 leaves them; a flag set by an expiry in the same cycle as its clearing write stays set.
- R10: A write changes only the bytes whose be bit is 1, and a write with be equal to 0 has no effect at all, including on reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe that advances the count |
| no_reboot | input | 1 | When high, the second expiry does not request reset |
| irq_enable | input | 1 | Gates the first-timeout flag onto irq |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset of the register accessed |
| wdata | input | 16 | Write data |
| be | input | 2 | Byte enables for wdata |
| rdata | output | 16 | Combinational read data for addr |
| irq | output | 1 | Timeout interrupt level |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume tick_en is a synchronous strobe held low except on cycles meant to advance the count, and that the register write inputs are stable across each clock edge. The bench drives every input a short delay after a rising edge, pulses tick_en for single cycles or short bursts, and keeps addr at offset 0x00 between accesses so the count is compared against the reference model on every cycle. Same-cycle collisions (reload with tick, clear with expiry) are produced on purpose, as they are legal and defined.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;

    localparam int unsigned DATA_W = 16;
    localparam int unsigned BE_W   = DATA_W / 8;
    localparam int unsigned ADDR_W = 5;

    // Register byte offsets
    localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT1  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT2  = 5'h06;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_INIT   = 5'h12;

    // Bit positions inside the registers
    localparam int unsigned FIRST_BIT  = 3;
    localparam int unsigned SECOND_BIT = 1;
    localparam int unsigned BOOT_BIT   = 2;
    localparam int unsigned HALT_BIT   = 11;

    typedef enum logic {
        STAGE_FIRST  = 1'b0,
        STAGE_SECOND = 1'b1
    } stage_e;

    typedef struct packed {
        logic reload;
        logic stat1;
        logic stat2;
        logic ctrl;
        logic init;
    } wr_sel_t;

endpackage

// File: rtl/wdt2_decode.sv
module wdt2_decode
    import wdt2_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be,
    output wr_sel_t           sel
);

    logic any_wr;

    always_comb begin
        any_wr     = wr_en && (be != '0);
        sel        = '0;
        sel.reload = any_wr && (addr == OFS_RELOAD);
        sel.stat1  = any_wr && (addr == OFS_STAT1);
        sel.stat2  = any_wr && (addr == OFS_STAT2);
        sel.ctrl   = any_wr && (addr == OFS_CTRL);
        sel.init   = any_wr && (addr == OFS_INIT);
    end

endmodule

// File: rtl/wdt2_regs.sv
module wdt2_regs
    import wdt2_pkg::*;
#(
    parameter  int unsigned CNT_W      = 10,
    parameter  int unsigned INIT_RESET = 4,
    parameter  int unsigned INIT_MIN   = 4,
    localparam int unsigned HI_W       = DATA_W - CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_sel_t           sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BE_W-1:0]   be,
    input  logic              set_first,
    input  logic              set_second,
    output logic              halt,
    output logic [CNT_W-1:0]  init_val,
    output logic [HI_W-1:0]   init_hi,
    output logic              flag_first,
    output logic              flag_second,
    output logic              flag_boot
);

    typedef struct packed {
        logic             halt;
        logic [CNT_W-1:0] init;
        logic [HI_W-1:0]  hi;
        logic             first;
        logic             second;
        logic             boot;
    } regs_t;

    regs_t             r_d, r_q;
    logic [DATA_W-1:0] cur_word;
    logic [DATA_W-1:0] merged;

    always_comb begin
        r_d      = r_q;
        cur_word = {r_q.hi, r_q.init};
        for (int b = 0; b < int'(BE_W); b++) begin
            merged[b*8 +: 8] = be[b] ? wdata[b*8 +: 8] : cur_word[b*8 +: 8];
        end

        if (sel.init) begin
            r_d.hi = merged[DATA_W-1:CNT_W];
            if (merged[CNT_W-1:0] >= CNT_W'(INIT_MIN)) begin
                r_d.init = merged[CNT_W-1:0];
            end
        end

        if (sel.ctrl && be[HALT_BIT/8]) begin
            r_d.halt = wdata[HALT_BIT];
        end

        if (sel.stat1 && be[FIRST_BIT/8] && wdata[FIRST_BIT]) begin
            r_d.first = 1'b0;
        end
        if (sel.stat2 && be[SECOND_BIT/8] && wdata[SECOND_BIT]) begin
            r_d.second = 1'b0;
        end
        if (sel.stat2 && be[BOOT_BIT/8] && wdata[BOOT_BIT]) begin
            r_d.boot = 1'b0;
        end

        // Events take priority over a clearing write
        if (set_first) begin
            r_d.first = 1'b1;
        end
        if (set_second) begin
            r_d.second = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.halt   <= 1'b1;
            r_q.init   <= CNT_W'(INIT_RESET);
            r_q.boot   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign halt        = r_q.halt;
    assign init_val    = r_q.init;
    assign init_hi     = r_q.hi;
    assign flag_first  = r_q.first;
    assign flag_second = r_q.second;
    assign flag_boot   = r_q.boot;

endmodule

// File: rtl/wdt2_counter.sv
module wdt2_counter
    import wdt2_pkg::*;
#(
    parameter int unsigned CNT_W      = 10,
    parameter int unsigned INIT_RESET = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             halt,
    input  logic             reload,
    input  logic             no_reboot,
    input  logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] count,
    output logic             first_exp,
    output logic             second_exp,
    output logic             rst_req
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        stage_e           stage;
        logic             rst_pulse;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d           = c_q;
        c_d.rst_pulse = 1'b0;
        first_exp     = 1'b0;
        second_exp    = 1'b0;

        if (reload) begin
            c_d.count = init_val;
            c_d.stage = STAGE_FIRST;
        end else if (tick_en && !halt) begin
            if (c_q.count == '0) begin
                c_d.count = init_val;
                if (c_q.stage == STAGE_FIRST) begin
                    first_exp = 1'b1;
                    c_d.stage = STAGE_SECOND;
                end else begin
                    second_exp    = 1'b1;
                    c_d.stage     = STAGE_FIRST;
                    c_d.rst_pulse = !no_reboot;
                end
            end else begin
                c_d.count = c_q.count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.count     <= CNT_W'(INIT_RESET);
            c_q.stage     <= STAGE_FIRST;
            c_q.rst_pulse <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign count   = c_q.count;
    assign rst_req = c_q.rst_pulse;

endmodule

// File: rtl/dual_stage_wdt.sv
module dual_stage_wdt
    import wdt2_pkg::*;
#(
    parameter  int unsigned CNT_W      = 10,
    parameter  int unsigned INIT_RESET = 4,
    parameter  int unsigned INIT_MIN   = 4,
    localparam int unsigned HI_W       = DATA_W - CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              no_reboot,
    input  logic              irq_enable,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BE_W-1:0]   be,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              rst_req
);

    wr_sel_t          sel;
    logic             halt;
    logic [CNT_W-1:0] init_val;
    logic [HI_W-1:0]  init_hi;
    logic             flag_first;
    logic             flag_second;
    logic             flag_boot;
    logic [CNT_W-1:0] count;
    logic             first_exp;
    logic             second_exp;
    logic             wr_reload;

    wdt2_decode u_decode (
        .wr_en (wr_en),
        .addr  (addr),
        .be    (be),
        .sel   (sel)
    );

    assign wr_reload = sel.reload;

    wdt2_regs #(
        .CNT_W      (CNT_W),
        .INIT_RESET (INIT_RESET),
        .INIT_MIN   (INIT_MIN)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .wdata       (wdata),
        .be          (be),
        .set_first   (first_exp),
        .set_second  (second_exp),
        .halt        (halt),
        .init_val    (init_val),
        .init_hi     (init_hi),
        .flag_first  (flag_first),
        .flag_second (flag_second),
        .flag_boot   (flag_boot)
    );

    wdt2_counter #(
        .CNT_W      (CNT_W),
        .INIT_RESET (INIT_RESET)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .halt       (halt),
        .reload     (wr_reload),
        .no_reboot  (no_reboot),
        .init_val   (init_val),
        .count      (count),
        .first_exp  (first_exp),
        .second_exp (second_exp),
        .rst_req    (rst_req)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_RELOAD: rdata[CNT_W-1:0] = count;
            OFS_STAT1:  rdata[FIRST_BIT] = flag_first;
            OFS_STAT2: begin
                rdata[SECOND_BIT] = flag_second;
                rdata[BOOT_BIT]   = flag_boot;
            end
            OFS_CTRL:   rdata[HALT_BIT] = halt;
            OFS_INIT:   rdata = {init_hi, init_val};
            default:    rdata = '0;
        endcase
    end

    assign irq = flag_first && irq_enable;

endmodule

// File: rtl/dual_stage_wdt_chk.sv
module dual_stage_wdt_chk #(
    parameter int unsigned CNT_W    = 10,
    parameter int unsigned INIT_MIN = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             no_reboot,
    input logic             rst_req,
    input logic             reload,
    input logic             halt,
    input logic             flag_first,
    input logic             flag_second,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] init_val
);

    // R2: the stored field never holds a rejected value
    p_init_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_val >= CNT_W'(INIT_MIN));

    // R4: halted and not reloaded means the count holds
    p_halt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !reload) |=> $stable(count));

    // R5: without a tick or reload the count holds
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !reload) |=> $stable(count));

    // R6: the first-timeout flag only rises after a tick
    p_first_after_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_first) |-> $past(tick_en));

    // R7: the reset request lasts a single cycle
    p_rst_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R7: a reset request comes with the second-timeout flag
    p_rst_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> flag_second);

    // R8: no reset request when no-reboot was high at the expiry
    p_no_reboot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !$past(no_reboot));

endmodule

bind dual_stage_wdt dual_stage_wdt_chk #(
    .CNT_W    (CNT_W),
    .INIT_MIN (INIT_MIN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .no_reboot   (no_reboot),
    .rst_req     (rst_req),
    .reload      (wr_reload),
    .halt        (halt),
    .flag_first  (flag_first),
    .flag_second (flag_second),
    .count       (count),
    .init_val    (init_val)
);

// File: tb/dual_stage_wdt_tb.sv
module dual_stage_wdt_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        no_reboot = 1'b0;
    logic        irq_enable = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  be = '0;
    logic [15:0] rdata;
    logic        irq;
    logic        rst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    dual_stage_wdt u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .no_reboot  (no_reboot),
        .irq_enable (irq_enable),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .be         (be),
        .rdata      (rdata),
        .irq        (irq),
        .rst_req    (rst_req)
    );

    always #5 clk = ~clk;

    // Reference model state
    int m_cnt = 4, m_second_stage = 0, m_s1 = 0, m_s2 = 0, m_boot = 1;
    int m_halt = 1, m_init = 4, m_hi = 0, m_rst = 0;
    int t_cnt, t_stage, t_s1, t_s2, t_boot, t_halt, t_init, t_hi, t_rst;
    int cur, merged;
    bit w;

    function automatic int model_read(input logic [4:0] a);
        case (a)
            5'h00:   return m_cnt;
            5'h04:   return m_s1 << 3;
            5'h06:   return (m_boot << 2) | (m_s2 << 1);
            5'h08:   return m_halt << 11;
            5'h12:   return (m_hi << 10) | m_init;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        case (a)
            5'h00:         return "R3";
            5'h04, 5'h06:  return "R9";
            5'h08:         return "R4";
            5'h12:         return "R2";
            default:       return "R10";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 4; m_second_stage = 0; m_s1 = 0; m_s2 = 0; m_boot = 1;
            m_halt = 1; m_init = 4; m_hi = 0; m_rst = 0;
        end else begin
            t_cnt = m_cnt; t_stage = m_second_stage; t_s1 = m_s1; t_s2 = m_s2;
            t_boot = m_boot; t_halt = m_halt; t_init = m_init; t_hi = m_hi; t_rst = 0;
            w = wr_en && (be != 2'b00);
            if (w && addr == 5'h00) begin
                t_cnt = m_init; t_stage = 0;
            end else if (tick_en && m_halt == 0) begin
                if (m_cnt == 0) begin
                    t_cnt = m_init;
                    if (m_second_stage == 0) begin
                        t_stage = 1;
                    end else begin
                        t_stage = 0;
                        t_rst = no_reboot ? 0 : 1;
                    end
                end else begin
                    t_cnt = m_cnt - 1;
                end
            end
            if (w && addr == 5'h12) begin
                cur = (m_hi << 10) | m_init;
                merged = (be[0] ? (int'(wdata) & 'hFF) : (cur & 'hFF)) |
                         (be[1] ? (int'(wdata) & 'hFF00) : (cur & 'hFF00));
                t_hi = merged >> 10;
                if ((merged & 'h3FF) >= 4) t_init = merged & 'h3FF;
            end
            if (w && addr == 5'h08 && be[1]) t_halt = wdata[11];
            if (w && addr == 5'h04 && be[0] && wdata[3]) t_s1 = 0;
            if (w && addr == 5'h06 && be[0] && wdata[1]) t_s2 = 0;
            if (w && addr == 5'h06 && be[0] && wdata[2]) t_boot = 0;
            if (!(w && addr == 5'h00) && tick_en && m_halt == 0 && m_cnt == 0) begin
                if (m_second_stage == 0) t_s1 = 1;
                else t_s2 = 1;
            end
            m_cnt = t_cnt; m_second_stage = t_stage; m_s1 = t_s1; m_s2 = t_s2;
            m_boot = t_boot; m_halt = t_halt; m_init = t_init; m_hi = t_hi; m_rst = t_rst;
        end
    end

    task automatic cmp(input logic [15:0] act, input int exp, input string tag);
        checks++;
        if (act !== 16'(exp)) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, 16'(exp));
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp(rdata, model_read(addr), tag_of(addr));
            cmp({15'd0, irq}, (m_s1 != 0 && irq_enable) ? 1 : 0, "R6");
            cmp({15'd0, rst_req}, m_rst, "R7");
        end
    end

    task automatic step(input bit wv, input logic [4:0] a, input logic [15:0] d,
                        input logic [1:0] b, input bit t);
        wr_en = wv; addr = a; wdata = d; be = b; tick_en = t;
        @(posedge clk);
        #2;
        wr_en = 0; addr = '0; wdata = '0; be = '0; tick_en = 0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic [1:0] b);
        step(1, a, d, b, 0);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) step(0, 5'h00, 16'h0, 2'b00, 1);
    endtask

    task automatic peek(input logic [4:0] a, input int exp, input string tag);
        addr = a;
        #1;
        cmp(rdata, exp, tag);
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1;

        // R1 reset state
        peek(5'h00, 'h0004, "R1 count");
        peek(5'h12, 'h0004, "R1 init");
        peek(5'h06, 'h0004, "R1 boot flag");
        peek(5'h08, 'h0800, "R1 halt");
        peek(5'h04, 'h0000, "R1 first flag");
        cmp({15'd0, irq}, 0, "R1 irq");
        cmp({15'd0, rst_req}, 0, "R1 rst_req");

        // R4 ticks while halted do nothing
        tick(3);
        peek(5'h00, 'h0004, "R4 halted count");

        // R2 initial value rules
        wr(5'h12, 16'h0002, 2'b11);
        peek(5'h12, 'h0004, "R2 value 2 ignored");
        wr(5'h12, 16'h0003, 2'b11);
        peek(5'h12, 'h0004, "R2 value 3 ignored");
        wr(5'h12, 16'hFC06, 2'b11);
        peek(5'h12, 'hFC06, "R2 upper bits and field");
        wr(5'h12, 16'h0100, 2'b10);
        peek(5'h12, 'h0106, "R10 high byte only");
        wr(5'h12, 16'h0006, 2'b11);
        wr(5'h12, 16'h0002, 2'b01);
        peek(5'h12, 'h0006, "R2 partial write to illegal field ignored");
        wr(5'h12, 16'h0009, 2'b00);
        peek(5'h12, 'h0006, "R10 be zero no write");

        // R3 reload
        wr(5'h00, 16'h0001, 2'b00);
        peek(5'h00, 'h0004, "R10 be zero no reload");
        wr(5'h00, 16'h0001, 2'b11);
        peek(5'h00, 'h0006, "R3 reload value");

        // R4 start the timer
        wr(5'h08, 16'h0000, 2'b11);
        peek(5'h08, 'h0000, "R4 halt cleared");
        wr(5'h08, 16'h0800, 2'b01);
        peek(5'h08, 'h0000, "R10 low byte cannot set halt");

        // R5 R6 first expiry
        irq_enable = 1;
        tick(6);
        peek(5'h00, 'h0000, "R5 count at zero");
        cmp({15'd0, irq}, 0, "R6 no irq before expiry");
        tick(1);
        peek(5'h00, 'h0006, "R5 reload on expiry");
        peek(5'h04, 'h0008, "R6 first flag");
        cmp({15'd0, irq}, 1, "R6 irq level");

        // R7 second expiry
        tick(7);
        cmp({15'd0, rst_req}, 1, "R7 reset pulse");
        peek(5'h06, 'h0006, "R7 second flag");
        step(0, 5'h00, 16'h0, 2'b00, 0);
        cmp({15'd0, rst_req}, 0, "R7 pulse ends");

        // R9 write-one-to-clear
        wr(5'h06, 16'h0002, 2'b01);
        peek(5'h06, 'h0004, "R9 clear second flag");
        wr(5'h04, 16'h0000, 2'b01);
        peek(5'h04, 'h0008, "R9 writing zero keeps flag");
        irq_enable = 0;
        #1;
        cmp({15'd0, irq}, 0, "R6 irq gated by enable");
        irq_enable = 1;
        wr(5'h04, 16'h0008, 2'b01);
        peek(5'h04, 'h0000, "R9 clear first flag");
        wr(5'h06, 16'h0004, 2'b01);
        peek(5'h06, 'h0000, "R9 clear boot flag");

        // R8 no-reboot: stage restarted at first after R7
        no_reboot = 1;
        tick(14);
        cmp({15'd0, rst_req}, 0, "R8 no reset request");
        peek(5'h06, 'h0002, "R8 second flag still set");
        no_reboot = 0;

        // R3 reload mid-stage returns to first stage
        wr(5'h06, 16'h0002, 2'b01);
        tick(7);
        wr(5'h00, 16'h0001, 2'b11);
        tick(7);
        peek(5'h06, 'h0000, "R3 reload returned to first stage");

        // R9 set wins over clear in the same cycle
        wr(5'h00, 16'h0001, 2'b11);
        tick(6);
        step(1, 5'h04, 16'h0008, 2'b01, 1);
        peek(5'h04, 'h0008, "R9 set wins");

        // Reload and tick in the same cycle: reload wins
        wr(5'h00, 16'h0001, 2'b11);
        step(1, 5'h00, 16'h0001, 2'b11, 1);
        peek(5'h00, 'h0006, "R3 reload beats tick");

        // R4 halt mid count
        tick(2);
        wr(5'h08, 16'h0800, 2'b10);
        tick(4);
        peek(5'h00, 'h0004, "R4 frozen mid count");
        wr(5'h08, 16'h0000, 2'b10);

        // R5 largest initial value
        wr(5'h12, 16'h03FF, 2'b11);
        wr(5'h00, 16'h0001, 2'b11);
        tick(1023);
        peek(5'h00, 'h0000, "R5 max value reaches zero");
        tick(1);
        peek(5'h00, 'h03FF, "R5 max value reload");
        idle_end();
    end

    task automatic idle_end();
        step(0, 5'h00, 16'h0, 2'b00, 0);
        step(0, 5'h00, 16'h0, 2'b00, 0);
        finish_run();
    endtask

endmodule